// File: doc/BRIEF.md
# DDR SDRAM Test-Pattern Command Sequencer

This block plays fixed, cycle-exact DDR SDRAM command loops for supply-current characterisation. It stops at the command bus: the data path, strobes, mode-register setup, refresh and any model of the memory are all outside it. In single-bank mode it opens one row in bank 0, reads it, and precharges it at the shortest row cycle. In four-bank mode it interleaves activates to banks 0 to 3, two cycles apart. Each bank is read with auto-precharge three cycles after its activate. A grade input selects a 166 MHz loop or a 200 MHz loop, and each grade has its own loop length.

A start pulse in idle latches mode and grade and loads a 16-bit pseudo-random address generator from a seed. The loop then repeats with a new row/column value on every pass. A stop request lets the current pass finish before the block returns to idle. Each cycle the block drives the four active-low command lines, a bank address, an address bus and a strobe that marks the first command of every pass. On NOP cycles the address and bank lines toggle in single-bank mode and stay frozen in four-bank mode.

Top module: `ddr_cmd_loop`

## Requirements
- R1: Commands are driven as {cs_n,ras_n,cas_n,we_n}: activate 0011, read 0101, precharge 0010, NOP 0111. No other value ever appears.
- R2: After reset and whenever idle, the block drives NOP, bank 0, address 0 and strobe low. A start pulse while idle makes the first activate of a pass appear in the next cycle.
- R3: Single-bank mode, grade 0 (166 MHz): a 9-cycle pass, all commands to bank 0. Activate at position 0, read at 3, precharge at 5, NOP everywhere else.
- R4: Single-bank mode, grade 1 (200 MHz): an 11-cycle pass, all commands to bank 0. Activate at 0, read at 3, precharge at 8, NOP everywhere else.
- R5: Four-bank mode, grade 0: a 10-cycle pass. Activates go to bank p/2 at even positions 0 to 6. Auto-precharge reads go to bank (p-3)/2 at odd positions 3 to 9. The remaining positions carry NOP.
- R6: Four-bank mode, grade 1: the same pattern as R5, followed by one extra NOP, giving an 11-cycle pass.
- R7: With row = the low 13 bits of the generator state, the address bus carries the following:
  - activate: row
  - precharge: row with bit 10 cleared
  - read: row with bits 1:0 cleared (burst-of-4 aligned) and bit 10 set for an auto-precharge read, clear for a plain read
- R8: The address generator is a right-shifting Galois register with tap mask 0xB400. Start loads it with the seed, or with 1 if the seed is 0. It advances once when a pass wraps into the next.
- R9: On a NOP inside a running pass, single-bank mode drives the bitwise inverse of the previous cycle's address and bank. Four-bank mode repeats them unchanged.
- R10: The loop strobe is high for exactly the cycle at position 0 of every pass.
- R11: A stop pulse at any position lets the current pass finish, and the cycle after its last command is idle. Stop at the last position itself ends the pass there. Stop while idle has no effect.
- R12: While a pass runs, changes on mode, grade, start or seed have no effect on the command stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin looping (sampled while idle) |
| stop_i | input | 1 | Finish the current pass, then idle |
| mode_i | input | 1 | 0 single-bank, 1 four-bank |
| grade_i | input | 1 | 0 166 MHz loop, 1 200 MHz loop |
| seed_i | input | 16 | Address generator seed |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | ADDR_W (13) | Row/column address |
| loop_stb_o | output | 1 | First command of a pass |

## Verification
The bench builds the block with the default 13-bit address. With this width, bit 10 and the truncation of the 16-bit generator state both show on the bus, so every address field of R7 is checked bit for bit. The bench sweeps all four mode and grade pairings, and with each it uses three seeds, one of them zero. Each run lasts three passes, so the generator steps and the pass wrap are exercised. In each run the stop pulse lands at a different position: the middle of a pass, the last position, or the first. Throughout each run the bench toggles start, mode, grade and seed, which brings R11 and R12 within reach in every configuration.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;

  localparam int GEN_W  = 16;
  localparam int BANK_W = 2;
  localparam int POS_W  = 4;
  localparam int AP_BIT = 10;
  localparam logic [GEN_W-1:0] GEN_TAPS = 16'hB400;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef struct packed {
    cmd_e              cmd;
    logic [BANK_W-1:0] bank;
    logic              apre;
  } slot_t;

  function automatic logic [POS_W-1:0] loop_len(input logic four, input logic fast);
    if (fast)      return POS_W'(11);
    else if (four) return POS_W'(10);
    else           return POS_W'(9);
  endfunction

  function automatic slot_t slot_at(input logic four, input logic fast,
                                    input logic [POS_W-1:0] pos);
    slot_t s;
    s.cmd  = CMD_NOP;
    s.bank = '0;
    s.apre = 1'b0;
    if (!four) begin
      if (pos == POS_W'(0))                      s.cmd = CMD_ACT;
      else if (pos == POS_W'(3))                 s.cmd = CMD_RD;
      else if (pos == (fast ? POS_W'(8) : POS_W'(5))) s.cmd = CMD_PRE;
    end else begin
      case (pos)
        POS_W'(0): begin s.cmd = CMD_ACT; s.bank = 2'd0; end
        POS_W'(2): begin s.cmd = CMD_ACT; s.bank = 2'd1; end
        POS_W'(3): begin s.cmd = CMD_RD;  s.bank = 2'd0; s.apre = 1'b1; end
        POS_W'(4): begin s.cmd = CMD_ACT; s.bank = 2'd2; end
        POS_W'(5): begin s.cmd = CMD_RD;  s.bank = 2'd1; s.apre = 1'b1; end
        POS_W'(6): begin s.cmd = CMD_ACT; s.bank = 2'd3; end
        POS_W'(7): begin s.cmd = CMD_RD;  s.bank = 2'd2; s.apre = 1'b1; end
        POS_W'(9): begin s.cmd = CMD_RD;  s.bank = 2'd3; s.apre = 1'b1; end
        default: ;
      endcase
    end
    return s;
  endfunction

  function automatic logic [GEN_W-1:0] gen_next(input logic [GEN_W-1:0] s);
    return (s >> 1) ^ (s[0] ? GEN_TAPS : '0);
  endfunction

  function automatic logic [GEN_W-1:0] gen_seed(input logic [GEN_W-1:0] s);
    return (s == '0) ? GEN_W'(1) : s;
  endfunction

endpackage

// File: rtl/tp_addr_gen.sv
module tp_addr_gen
  import ddr_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GEN_W-1:0] seed,
  input  logic             step,
  output logic [GEN_W-1:0] state
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= GEN_W'(1);
    else if (load) state <= gen_seed(seed);
    else if (step) state <= gen_next(state);
  end

  // R8
  gen_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);

endmodule

// File: rtl/tp_seq_ctrl.sv
module tp_seq_ctrl
  import ddr_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             mode,
  input  logic             grade,
  output logic             running,
  output logic [POS_W-1:0] pos,
  output logic             four_q,
  output logic             fast_q,
  output logic             load_evt,
  output logic             wrap_evt,
  output logic             first_evt
);

  logic             stop_q;
  logic             last_evt;
  logic             end_evt;
  logic [POS_W-1:0] len_q;

  assign len_q     = loop_len(four_q, fast_q);
  assign load_evt  = start && !running;
  assign last_evt  = running && (pos == len_q - POS_W'(1));
  assign end_evt   = last_evt && (stop_q || stop);
  assign wrap_evt  = last_evt && !end_evt;
  assign first_evt = running && (pos == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      pos     <= '0;
      four_q  <= 1'b0;
      fast_q  <= 1'b0;
      stop_q  <= 1'b0;
    end else if (load_evt) begin
      running <= 1'b1;
      pos     <= '0;
      four_q  <= mode;
      fast_q  <= grade;
      stop_q  <= 1'b0;
    end else if (running) begin
      if (last_evt) begin
        pos    <= '0;
        stop_q <= 1'b0;
        if (end_evt) running <= 1'b0;
      end else begin
        pos <= pos + POS_W'(1);
        if (stop) stop_q <= 1'b1;
      end
    end
  end

  // R3 R4 R5 R6
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> pos < len_q);

  // R12
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> ($stable(four_q) && $stable(fast_q)));

  // R11
  stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> !running);

  // R11
  loop_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (running && pos == '0));

endmodule

// File: rtl/tp_cmd_drive.sv
module tp_cmd_drive
  import ddr_cmd_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              running,
  input  logic              four,
  input  logic              fast,
  input  logic [POS_W-1:0]  pos,
  input  logic [GEN_W-1:0]  gen,
  output cmd_e              cmd,
  output logic [BANK_W-1:0] bank,
  output logic [ADDR_W-1:0] addr
);

  slot_t             slot;
  logic [ADDR_W-1:0] row;
  logic [ADDR_W-1:0] prev_addr;
  logic [BANK_W-1:0] prev_bank;
  logic              nop_evt;

  assign slot    = slot_at(four, fast, pos);
  assign row     = gen[ADDR_W-1:0];
  assign nop_evt = running && (slot.cmd == CMD_NOP);

  always_comb begin
    cmd  = CMD_NOP;
    bank = '0;
    addr = '0;
    if (running) begin
      cmd = slot.cmd;
      case (slot.cmd)
        CMD_ACT: begin
          bank = slot.bank;
          addr = row;
        end
        CMD_RD: begin
          bank         = slot.bank;
          addr         = row;
          addr[1:0]    = 2'b00;
          addr[AP_BIT] = slot.apre;
        end
        CMD_PRE: begin
          bank         = slot.bank;
          addr         = row;
          addr[AP_BIT] = 1'b0;
        end
        default: begin
          bank = four ? prev_bank : ~prev_bank;
          addr = four ? prev_addr : ~prev_addr;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_addr <= '0;
      prev_bank <= '0;
    end else begin
      prev_addr <= addr;
      prev_bank <= bank;
    end
  end

  // R9
  nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nop_evt && four && $past(running)) |-> ($stable(addr) && $stable(bank)));

endmodule

// File: rtl/ddr_cmd_loop.sv
module ddr_cmd_loop
  import ddr_cmd_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              mode_i,
  input  logic              grade_i,
  input  logic [15:0]       seed_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              loop_stb_o
);

  logic             running;
  logic [POS_W-1:0] pos;
  logic             four_q;
  logic             fast_q;
  logic             load_evt;
  logic             wrap_evt;
  logic             first_evt;
  logic [GEN_W-1:0] gen;
  cmd_e             cmd;

  tp_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_i),
    .stop      (stop_i),
    .mode      (mode_i),
    .grade     (grade_i),
    .running   (running),
    .pos       (pos),
    .four_q    (four_q),
    .fast_q    (fast_q),
    .load_evt  (load_evt),
    .wrap_evt  (wrap_evt),
    .first_evt (first_evt)
  );

  tp_addr_gen u_gen (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_evt),
    .seed  (seed_i),
    .step  (wrap_evt),
    .state (gen)
  );

  tp_cmd_drive #(.ADDR_W(ADDR_W)) u_drive (
    .clk     (clk),
    .rst_n   (rst_n),
    .running (running),
    .four    (four_q),
    .fast    (fast_q),
    .pos     (pos),
    .gen     (gen),
    .cmd     (cmd),
    .bank    (ba_o),
    .addr    (addr_o)
  );

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;
  assign loop_stb_o = first_evt;

  // R1
  cmd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT) || (cmd == CMD_RD) || (cmd == CMD_PRE) || (cmd == CMD_NOP));

  // R2
  idle_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (cmd == CMD_NOP && !loop_stb_o && addr_o == '0 && ba_o == '0));

  // R7
  rda_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD && four_q) |-> (addr_o[AP_BIT] && addr_o[1:0] == 2'b00));

  // R10
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_stb_o |=> !loop_stb_o);

endmodule

// File: tb/ddr_cmd_loop_tb_top.sv
`timescale 1ns/1ps
module ddr_cmd_loop_tb_top;

  localparam int AW = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0, stop_i = 1'b0, mode_i = 1'b0, grade_i = 1'b0;
  logic [15:0]   seed_i = 16'h0;
  logic          cs_n_o, ras_n_o, cas_n_o, we_n_o, loop_stb_o;
  logic [1:0]    ba_o;
  logic [AW-1:0] addr_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ddr_cmd_loop #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .mode_i(mode_i), .grade_i(grade_i), .seed_i(seed_i),
    .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
    .ba_o(ba_o), .addr_o(addr_o), .loop_stb_o(loop_stb_o)
  );

  // reference model state
  bit          m_run = 0, m_four = 0, m_fast = 0, m_stop = 0;
  int          m_pos = 0;
  logic [15:0] m_gen = 16'h1;
  logic [AW-1:0] m_paddr = '0;
  logic [1:0]    m_pbank = '0;
  int          stb_seen = 0;

  // R1 encodings
  localparam logic [3:0] E_ACT = 4'b0011, E_RD = 4'b0101, E_PRE = 4'b0010, E_NOP = 4'b0111;

  function automatic int plen(bit four, bit fast);
    return fast ? 11 : (four ? 10 : 9);
  endfunction

  function automatic logic [15:0] step_gen(logic [15:0] s);
    logic fb = s[0];
    logic [15:0] r = {1'b0, s[15:1]};
    if (fb) r = r ^ 16'hB400;
    return r;
  endfunction

  task automatic expect_now(output logic [3:0] ec, output logic [1:0] eb,
                            output logic [AW-1:0] ea, output bit es, output bit is_nop);
    logic [AW-1:0] row;
    ec = E_NOP; eb = 2'd0; ea = '0; es = 0; is_nop = 0;
    if (!m_run) return;
    row = m_gen[AW-1:0];
    es = (m_pos == 0);
    if (m_four) begin
      if (m_pos % 2 == 0 && m_pos <= 6) begin
        ec = E_ACT; eb = 2'(m_pos / 2); ea = row;
      end else if (m_pos % 2 == 1 && m_pos >= 3 && m_pos <= 9) begin
        ec = E_RD; eb = 2'((m_pos - 3) / 2);
        ea = (row & ~AW'(13'h0403)) | AW'(13'h0400);
      end else begin
        is_nop = 1; eb = m_pbank; ea = m_paddr;
      end
    end else begin
      if (m_pos == 0) begin ec = E_ACT; ea = row; end
      else if (m_pos == 3) begin ec = E_RD; ea = row & ~AW'(13'h0403); end
      else if (m_pos == (m_fast ? 8 : 5)) begin ec = E_PRE; ea = row & ~AW'(13'h0400); end
      else begin is_nop = 1; eb = ~m_pbank; ea = ~m_paddr; end
    end
  endtask

  function automatic string cfg_tag();
    if (!m_run) return "R2";
    if (!m_four) return m_fast ? "R4" : "R3";
    return m_fast ? "R6" : "R5";
  endfunction

  // one clock: check outputs, apply inputs, advance model
  task automatic cyc(bit st, bit sp, bit md, bit gr, logic [15:0] sd);
    logic [3:0] ec, gc; logic [1:0] eb; logic [AW-1:0] ea; bit es, nop;
    @(negedge clk);
    expect_now(ec, eb, ea, es, nop);
    gc = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
    n_cmp++;
    if (loop_stb_o !== es) begin
      n_bad++;
      $display("FAIL R10 strobe pos=%0d got=%b exp=%b", m_pos, loop_stb_o, es);
    end else if (gc !== ec || ba_o !== eb) begin
      n_bad++;
      $display("FAIL %s R1 cmd/bank pos=%0d got=%b/%0d exp=%b/%0d", cfg_tag(), m_pos, gc, ba_o, ec, eb);
    end else if (addr_o !== ea) begin
      n_bad++;
      $display("FAIL %s pos=%0d addr got=%h exp=%h", nop ? "R9" : "R7 R8", m_pos, addr_o, ea);
    end
    if (loop_stb_o === 1'b1) stb_seen++;
    start_i = st; stop_i = sp; mode_i = md; grade_i = gr; seed_i = sd;
    m_paddr = ea; m_pbank = eb;
    if (!m_run) begin
      if (st) begin
        m_run = 1; m_pos = 0; m_four = md; m_fast = gr; m_stop = 0;
        m_gen = (sd == 16'h0) ? 16'h1 : sd;
      end
    end else if (m_pos == plen(m_four, m_fast) - 1) begin
      if (m_stop || sp) m_run = 0;
      else m_gen = step_gen(m_gen);
      m_pos = 0; m_stop = 0;
    end else begin
      m_pos++;
      if (sp) m_stop = 1;
    end
  endtask

  task automatic chk(bit ok, string tag, int got, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  initial begin
    logic [15:0] seeds [3];
    seeds[0] = 16'hACE1; seeds[1] = 16'h0000; seeds[2] = 16'h8000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 idle after reset; R11 stop while idle ignored
    for (int i = 0; i < 4; i++) cyc(0, 1, 1, 1, 16'h1234);
    for (int cfg = 0; cfg < 4; cfg++) begin
      for (int k = 0; k < 3; k++) begin
        bit fo = cfg[1];
        bit fa = cfg[0];
        int len = plen(fo, fa);
        int off = (k == 0) ? 4 : ((k == 1) ? len - 1 : 0);
        stb_seen = 0;
        cyc(1, 0, fo, fa, seeds[k]);
        // R12: mode/grade/start/seed toggled during the run
        for (int c = 0; c < 2 * len + off; c++)
          cyc(c[0], 0, ~fo, ~fa, 16'hFFFF - 16'(c));
        cyc(0, 1, ~fo, fa, 16'h5555);          // R11 stop in third pass
        for (int c = 0; c < 14; c++) cyc(0, 0, fo, fa, 16'h0);
        chk(stb_seen == 3, "R10 R11 pass count", stb_seen, 3);
        chk(!m_run && cs_n_o === 1'b0 && we_n_o === 1'b1, "R2 R11 idle NOP after stop",
            {31'd0, m_run}, 0);
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule